// File: doc/BRIEF.md
# Multichannel ADC Serial Output Interface

This block is the digital output side of a multichannel, simultaneous-sampling 24-bit converter. At each conversion it accepts one parallel word per channel from a sample source and sends the words out serially, most significant bit first. The protocol is chosen by pins. In SPI mode the block times the conversions itself, lowers a data-ready strobe and shifts on a serial clock that the host supplies. In frame-sync mode the host drives a frame clock, and each rising edge of that clock starts a frame.

The words leave either on one line per channel or as a time-division stream of all channels on line 0. In the stream, slots of powered-down channels are either kept as zeros or removed. After the last local bit, the stream carries the bits taken from a daisy-chain input, so several devices can share one line. The SPI conversion period comes from the operating mode and the clock-divider pin. A synchronisation input restarts all channels together and holds back output for a settling count of conversions.

Samples arrive on a valid/ready port. `s_ready` is high only in the single cycle in which a settled conversion takes place. If `s_valid` is low in that cycle, the conversion is skipped: nothing is loaded and data-ready stays high. The source must hold its word steady until the transfer. There is no buffering, so a source that is late loses that conversion.

Top module: `adc_serial_out`

## Requirements
- R1: The SPI conversion period is a fixed number of clocks set by `mode_sel` and `clk_div`. With U = `UNIT`, the periods are: mode 00 gives U, mode 01 gives 2U, mode 10 gives 2U if `clk_div`=1 and U otherwise, and mode 11 gives 10U if `clk_div`=1 and 2U otherwise. Successive falls of `drdy` are exactly one period apart.
- R2: In SPI mode, `drdy` goes low in the cycle after a conversion loads, and the MSB of each word is already on its line at that point. Each falling edge of `sclk` (seen as high then low on successive clock edges) moves every line to the next lower bit.
- R3: In SPI mode, `drdy` returns high after the first falling edge of `sclk` following a load. It also returns high one cycle before every conversion. `drdy` is high out of reset.
- R4: `fmt_sel[0]`=1 selects frame-sync mode. In this mode each rising edge of `fsync` is a conversion, the MSB appears one cycle after that edge, and `drdy` stays high.
- R5: With `fmt_sel[1]`=0 (discrete lines), line i carries channel i, which is taken from `s_data[i*24 +: 24]`. The line of a channel with `pwdn[i]`=1 sends all zeros.
- R6: With `fmt_sel[1]`=1 and `fmt_sel[2]`=0 (time-division, fixed slots), line 0 sends channel 0 first, then channels 1, 2 and so on. The slot of a powered-down channel is sent as 24 zeros, and lines 1 and above stay 0.
- R7: With `fmt_sel[1]`=1 and `fmt_sel[2]`=1 (time-division, dynamic slots), powered-down channels are left out and the remaining channels close up in channel order.
- R8: In time-division mode, once all local slots have been sent, line 0 shows the `din` value captured at the most recent `sclk` falling edge.
- R9: While `sync_n` is low there are no conversions, `drdy` is high and every line reads 0. After release, the first `SETTLE` conversions are dropped, so in SPI mode the first fall of `drdy` comes (`SETTLE`+1) periods after the release.
- R10: `s_ready` pulses only for a settled conversion. When `s_valid` is low at that point, nothing is loaded and `drdy` does not fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 2 | Operating mode (00 fast, 01 fine, 10 low power, 11 slow) |
| clk_div | input | 1 | Master-clock divider setting |
| fmt_sel | input | 3 | [0] frame-sync, [1] time-division, [2] dynamic slots |
| pwdn | input | NCH | Per-channel power-down |
| sync_n | input | 1 | Active-low restart of all channels |
| s_valid | input | 1 | Sample words valid |
| s_ready | output | 1 | Block takes the sample words this cycle |
| s_data | input | NCH*24 | Sample words, channel i at bits i*24 upward |
| sclk | input | 1 | Serial clock from the host |
| fsync | input | 1 | Frame clock in frame-sync mode |
| din | input | 1 | Daisy-chain serial input |
| drdy | output | 1 | Data-ready strobe, active low |
| dout | output | NCH | Serial data lines |

## Verification
The bench builds the block with four channels, `UNIT`=32 and `SETTLE`=2. The short unit brings every mode and divider period, including the 10U period, within a few thousand cycles. The slowest period, 320 clocks, leaves room for a complete host read of a 96-bit stream plus chained bits within one conversion. Setting `SETTLE` to 2 makes the delayed first data-ready and the zero output during settling directly observable in every restart.

// File: rtl/aso_pkg.sv
package aso_pkg;
  typedef enum logic [1:0] {
    MD_FAST   = 2'b00,
    MD_FINE   = 2'b01,
    MD_LOWPWR = 2'b10,
    MD_SLOW   = 2'b11
  } op_mode_e;

  // clocks per conversion as a multiple of the base unit
  function automatic int unsigned conv_clocks(input logic [1:0] m, input logic div,
                                              input int unsigned unit);
    case (op_mode_e'(m))
      MD_FAST:   return unit;
      MD_FINE:   return 2 * unit;
      MD_LOWPWR: return div ? 2 * unit : unit;
      default:   return div ? 10 * unit : 2 * unit;
    endcase
  endfunction
endpackage

// File: rtl/aso_conv_timer.sv
module aso_conv_timer import aso_pkg::*; #(
  parameter int unsigned UNIT   = 256,
  parameter int unsigned SETTLE = 76
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic       frame_mode,
  input  logic [1:0] mode_sel,
  input  logic       clk_div,
  input  logic       fsync,
  output logic       conv_evt,
  output logic       pre_evt
);
  localparam int CW = $clog2(10 * UNIT + 1);
  localparam int SW = $clog2(SETTLE + 2);

  logic [CW-1:0] cnt, period;
  logic [SW-1:0] scnt;
  logic          fsync_q, evt_raw, settled;

  assign period   = CW'(conv_clocks(mode_sel, clk_div, UNIT));
  assign evt_raw  = frame_mode ? (fsync & ~fsync_q) : (cnt == period - 1'b1);
  assign settled  = (scnt == SW'(SETTLE));
  assign conv_evt = sync_n & evt_raw & settled;
  assign pre_evt  = ~frame_mode & (cnt == period - CW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      scnt    <= '0;
      fsync_q <= 1'b0;
    end else begin
      fsync_q <= fsync;
      if (!sync_n) begin
        cnt  <= '0;
        scnt <= '0;
      end else begin
        cnt <= (cnt >= period - 1'b1) ? '0 : cnt + 1'b1;
        if (evt_raw && !settled) scnt <= scnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aso_frame_packer.sv
module aso_frame_packer #(
  parameter int NCH = 8,
  parameter int W   = 24
) (
  input  logic [NCH*W-1:0]             samples,
  input  logic [NCH-1:0]               pwdn,
  input  logic                         squeeze,
  output logic [NCH*W-1:0]             image,
  output logic [$clog2(NCH*W+1)-1:0]   nbits
);
  localparam int BW = $clog2(NCH * W + 1);

  // slot 0 sits at the top of the image so a left shift sends it first
  always_comb begin
    int k;
    image = '0;
    k     = 0;
    for (int j = 0; j < NCH; j++) begin
      if (!pwdn[j]) image[(NCH-1-k)*W +: W] = samples[j*W +: W];
      if (!pwdn[j] || !squeeze) k = k + 1;
    end
    nbits = BW'(k * W);
  end
endmodule

// File: rtl/aso_bit_shifter.sv
module aso_bit_shifter #(
  parameter int NCH = 8,
  parameter int W   = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        load,
  input  logic [NCH*W-1:0]            image,
  input  logic [$clog2(NCH*W+1)-1:0]  nbits,
  input  logic                        tdm,
  input  logic                        sclk_fall,
  input  logic                        din,
  output logic [NCH-1:0]              dout
);
  localparam int TOT = NCH * W;
  localparam int BW  = $clog2(TOT + 1);

  logic [TOT-1:0] sh, lane_lsb;
  logic [BW-1:0]  sent;
  logic           chain_q;

  for (genvar g = 0; g < TOT; g++) begin : g_mask
    assign lane_lsb[g] = ((g % W) == 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      sent    <= '0;
      chain_q <= 1'b0;
    end else if (clr) begin
      sh      <= '0;
      sent    <= '0;
    end else if (load) begin
      sh      <= image;
      sent    <= '0;
    end else if (sclk_fall) begin
      sh      <= tdm ? (sh << 1) : ((sh << 1) & ~lane_lsb);
      chain_q <= din;
      if (sent < nbits) sent <= sent + 1'b1;
    end
  end

  always_comb begin
    dout = '0;
    if (tdm) dout[0] = (sent < nbits) ? sh[TOT-1] : chain_q;
    else
      for (int i = 0; i < NCH; i++) dout[i] = sh[(NCH-1-i)*W + W-1];
  end
endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out #(
  parameter int          NCH    = 8,
  parameter int          W      = 24,
  parameter int unsigned UNIT   = 256,
  parameter int unsigned SETTLE = 76
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             clk_div,
  input  logic [2:0]       fmt_sel,
  input  logic [NCH-1:0]   pwdn,
  input  logic             sync_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [NCH*W-1:0] s_data,
  input  logic             sclk,
  input  logic             fsync,
  input  logic             din,
  output logic             drdy,
  output logic [NCH-1:0]   dout
);
  localparam int BW = $clog2(NCH * W + 1);

  logic             conv_evt, pre_evt, load, sclk_q, sclk_fall;
  logic [NCH*W-1:0] image;
  logic [BW-1:0]    nbits;

  assign sclk_fall = sclk_q & ~sclk;
  assign s_ready   = conv_evt;
  assign load      = conv_evt & s_valid;

  aso_conv_timer #(.UNIT(UNIT), .SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .frame_mode(fmt_sel[0]),
    .mode_sel(mode_sel), .clk_div(clk_div), .fsync(fsync),
    .conv_evt(conv_evt), .pre_evt(pre_evt)
  );

  aso_frame_packer #(.NCH(NCH), .W(W)) u_pack (
    .samples(s_data), .pwdn(pwdn), .squeeze(fmt_sel[1] & fmt_sel[2]),
    .image(image), .nbits(nbits)
  );

  aso_bit_shifter #(.NCH(NCH), .W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(~sync_n), .load(load), .image(image),
    .nbits(nbits), .tdm(fmt_sel[1]), .sclk_fall(sclk_fall), .din(din),
    .dout(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      drdy   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (!sync_n || fmt_sel[0])      drdy <= 1'b1;
      else if (load)                  drdy <= 1'b0;
      else if (pre_evt || sclk_fall)  drdy <= 1'b1;
    end
  end
endmodule

// File: rtl/aso_chk.sv
module aso_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync_n,
  input logic [2:0]     fmt_sel,
  input logic           s_valid,
  input logic           s_ready,
  input logic           sclk,
  input logic           drdy,
  input logic [NCH-1:0] dout
);
  AST_SYNC_HOLDS_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> drdy);                                                   // R9
  AST_FRAME_DRDY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_sel[0] |=> drdy);                                                // R4
  AST_FALL_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> $past(s_valid && s_ready));                         // R10
  AST_READY_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> sync_n);                                                 // R10
  AST_TDM_SPARE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_sel[1] |-> ((dout >> 1) == '0));                                 // R6
  AST_SCLK_RAISES_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_sel[0] && sync_n && $past(sclk) && !sclk && !(s_valid && s_ready)) |=> drdy); // R3
endmodule

bind adc_serial_out aso_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_adc_serial_out.sv
module tb_adc_serial_out;
  localparam int NCH = 4, W = 24, UNIT = 32, SETTLE = 2;
  localparam logic [23:0] D0 = 24'hA5C3F1, D1 = 24'h3C0F5A,
                          D2 = 24'h96E1B7, D3 = 24'h80007E;
  // {mode[1:0], clk_div, period[8:0]}
  localparam logic [11:0] TBL [8] = '{
    {2'b00, 1'b0, 9'd32},  {2'b00, 1'b1, 9'd32},
    {2'b01, 1'b0, 9'd64},  {2'b01, 1'b1, 9'd64},
    {2'b10, 1'b0, 9'd32},  {2'b10, 1'b1, 9'd64},
    {2'b11, 1'b0, 9'd64},  {2'b11, 1'b1, 9'd320}};

  logic clk = 0, rst_n = 0, clk_div = 0, sync_n = 1, s_valid = 1;
  logic sclk = 0, fsync = 0, din = 0;
  logic [1:0] mode_sel = 0;
  logic [2:0] fmt_sel = 0;
  logic [NCH-1:0] pwdn = 0, dout;
  logic s_ready, drdy, drdy_after1;
  logic [NCH*W-1:0] s_data = {D3, D2, D1, D0};
  logic [127:0] cap [NCH];
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_serial_out #(.NCH(NCH), .W(W), .UNIT(UNIT), .SETTLE(SETTLE)) dut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic restart();
    sync_n = 0;
    @(negedge clk);
    sync_n = 1;
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (drdy !== 1'b0) begin @(negedge clk); n++; end
  endtask

  task automatic rd(input int nb);
    for (int l = 0; l < NCH; l++) cap[l] = '0;
    for (int i = 0; i < nb; i++) begin
      for (int l = 0; l < NCH; l++) cap[l] = {cap[l][126:0], dout[l]};
      if (i == 1) drdy_after1 = drdy;
      sclk = 1; @(negedge clk);
      sclk = 0; @(negedge clk);
    end
  endtask

  task automatic run_all();
    int n, m, rdy, falls;
    // reset state
    repeat (3) @(negedge clk);
    chk("R3 reset drdy", drdy, 1);
    chk("R9 reset dout", dout, 0);
    chk("R10 reset s_ready", s_ready, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R9: period and settling per mode, table driven
    for (int t = 0; t < 8; t++) begin
      mode_sel = TBL[t][11:10];
      clk_div  = TBL[t][9];
      restart();
      wait_low(n);
      chk($sformatf("R9 first drdy fall entry %0d", t), n, (SETTLE + 1) * TBL[t][8:0]);
      m = 0;
      while (drdy === 1'b0) begin @(negedge clk); m++; end
      while (drdy !== 1'b0) begin @(negedge clk); m++; end
      chk($sformatf("R1 period entry %0d", t), m, TBL[t][8:0]);
    end

    // discrete SPI read, channel 2 powered down (slow mode, 320 clocks)
    mode_sel = 2'b11; clk_div = 1; fmt_sel = 3'b000; pwdn = 4'b0100;
    restart(); wait_low(n);
    rd(24);
    chk("R2 line0 word", cap[0][23:0], D0);
    chk("R5 line1 word", cap[1][23:0], D1);
    chk("R5 pwdn line2 zero", cap[2][23:0], 0);
    chk("R5 line3 word", cap[3][23:0], D3);
    chk("R3 drdy high after first sclk fall", drdy_after1, 1);

    // fixed-slot TDM, channel 1 powered down, chain input high
    fmt_sel = 3'b010; pwdn = 4'b0010; din = 1;
    restart(); wait_low(n);
    rd(100);
    chk("R6 R8 fixed stream", cap[0], {28'h0, D0, 24'h0, D2, D3, 4'hF});
    chk("R6 spare lines", {cap[1][99:0], cap[2][99:0], cap[3][99:0]} != 0, 0);

    // dynamic-slot TDM
    fmt_sel = 3'b110;
    restart(); wait_low(n);
    rd(76);
    chk("R7 R8 dynamic stream", cap[0], {52'h0, D0, D2, D3, 4'hF});
    din = 0;

    // R10: source not valid
    fmt_sel = 3'b000; pwdn = 0; s_valid = 0;
    restart();
    rdy = 0; falls = 0;
    for (int i = 0; i < 5 * 320; i++) begin
      @(negedge clk);
      if (s_ready) rdy++;
      if (drdy !== 1'b1) falls++;
    end
    chk("R10 ready pulses", rdy, 3);
    chk("R10 no drdy fall without valid", falls, 0);
    s_valid = 1;

    // R9: held in sync
    sync_n = 0; falls = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (drdy !== 1'b1 || dout !== 0) falls++;
    end
    chk("R9 sync hold", falls, 0);
    sync_n = 1;

    // frame-sync, discrete
    fmt_sel = 3'b001;
    restart();
    for (int r = 0; r < 3; r++) begin
      fsync = 1; @(negedge clk);
      if (r == 1) chk("R9 settling lines zero", dout, 0);
      if (r == 2) chk("R4 MSB after fsync rise", dout, {D3[23], D2[23], D1[23], D0[23]});
      @(negedge clk);
      fsync = 0; @(negedge clk); @(negedge clk);
    end
    chk("R4 drdy stays high", drdy, 1);
    rd(24);
    chk("R4 frame line0", cap[0][23:0], D0);
    chk("R4 frame line3", cap[3][23:0], D3);
  endtask

  initial begin
    fork
      begin run_all(); done = 1; end
      begin repeat (150000) @(posedge clk); end
    join_any
    disable fork;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule